// File: doc/BRIEF.md
# Parallel-Latch to SPI Echo Bridge

A host processor places one byte on an 8-bit parallel bus and then raises a separate trigger line. The bridge runs on the fabric clock (48 MHz in the target system, supplied by the host). It brings the trigger into that clock domain through a two-stage synchroniser and detects its rising edge. On that edge it copies the bus into a holding register and sets a sticky `data_ready` flag. The host keeps the trigger low while it changes the bus and raises it only once the bus is stable. This is why only a rising edge may capture, and never a level or a falling edge.

The host reads the byte back as an SPI master in mode 0 (clock idles low, data sampled on the rising SCK edge, MSB first). SCK and the active-low select are each synchronised the same way, and their edges are found in the fabric clock domain. This limits SCK to a rate well below the fabric clock. The master's data-out line plays no part in a plain echo and has no pin.

The SPI side is a three-state machine. `SPI_IDLE` is the deselected state, in which MISO is driven 0 and its output enable is low. The `IDLE→SHIFT` transition, on a synchronised select fall, loads the shift register from the holding register. `SPI_SHIFT` moves the next bit to MISO on each synchronised SCK falling edge and counts rising edges. The `SHIFT→DONE` transition, on the eighth rising edge, pulses transfer-complete, which clears `data_ready`. `SPI_DONE` holds MISO at 0 and ignores SCK. The `SHIFT→IDLE` and `DONE→IDLE` transitions, on a synchronised select rise, return the machine to `SPI_IDLE`.

Top module: `par_spi_echo`

## Requirements
- R1: After reset, `data_ready`, `spi_miso` and `spi_miso_oe` are all 0.
- R2: When `host_trig` goes from 0 to 1, `host_data` as seen at the third rising clock edge after the change is stored, and `data_ready` reads 1 after that third edge (it still reads 0 after the second).
- R3: Holding `host_trig` high while `host_data` changes, and then lowering it, stores nothing and does not set `data_ready`.
- R4: Changing `host_data` while `host_trig` stays low stores nothing and does not set `data_ready`.
- R5: A falling edge of `spi_cs_n` loads the held byte. `spi_miso` presents bit 7 first and moves to the next lower bit after each SCK falling edge, so the master reads the byte MSB first on SCK rising edges.
- R6: While `spi_cs_n` is high, `spi_miso` and `spi_miso_oe` are 0, and SCK activity changes neither output nor `data_ready`.
- R7: The eighth SCK rising edge of a selected transfer clears `data_ready`. A transfer that is deselected before eight rising edges leaves the flag set.
- R8: A capture during a transfer does not change the bits being shifted, and the new byte is returned by the next transfer. If a capture and a transfer completion fall in the same cycle, `data_ready` ends at 1.
- R9: After the eighth rising edge, `spi_miso` stays 0 with `spi_miso_oe` still 1, and further SCK edges are ignored until `spi_cs_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 8 | Parallel byte from the host |
| host_trig | input | 1 | Capture trigger, active on its rising edge |
| spi_sck | input | 1 | SPI clock from the master, idles low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | High while MISO should be driven onto the shared line |
| data_ready | output | 1 | Sticky flag: a byte was captured and not yet fully read |

## Verification
A state machine stuck in or skipping a state shows at `spi_miso_oe` or `spi_miso` in the first fabric cycle after the synchronised select or SCK edge that should have moved it. A wrong bit count shows as a cleared or uncleared `data_ready` one cycle after the eighth rising edge. A corrupted holding register stays hidden until the next read, where it appears as wrong MISO bits. The bench therefore compares all three outputs against a behavioural model in every cycle, and adds directed reads that decode whole bytes.

// File: rtl/par_spi_echo_pkg.sv
package par_spi_echo_pkg;

    typedef enum logic [1:0] {
        SPI_IDLE  = 2'd0,
        SPI_SHIFT = 2'd1,
        SPI_DONE  = 2'd2
    } spi_state_t;

endpackage

// File: rtl/pse_sync.sv
module pse_sync #(
    parameter int              WIDTH   = 1,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pse_capture.sv
module pse_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_s,
    input  logic [DATA_W-1:0] par_data,
    input  logic              xfer_done,
    output logic [DATA_W-1:0] hold,
    output logic              ready,
    output logic              cap_evt
);

    logic              trig_d;
    logic [DATA_W-1:0] hold_mux;
    logic              ready_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_d <= 1'b0;
        end else begin
            trig_d <= trig_s;
        end
    end

    assign cap_evt = trig_s & ~trig_d;

    // explicit load-source selection for the holding register
    always_comb begin
        unique case (cap_evt)
            1'b1:    hold_mux = par_data;
            default: hold_mux = hold;
        endcase
    end

    // capture takes precedence over clear
    always_comb begin
        if (cap_evt) begin
            ready_nxt = 1'b1;
        end else if (xfer_done) begin
            ready_nxt = 1'b0;
        end else begin
            ready_nxt = ready;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold  <= '0;
            ready <= 1'b0;
        end else begin
            hold  <= hold_mux;
            ready <= ready_nxt;
        end
    end

    a_r2_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (hold == $past(par_data)));

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(hold));

    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !cap_evt) |=> !ready);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> ready);

endmodule

// File: rtl/pse_spi_tx.sv
module pse_spi_tx
    import par_spi_echo_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              cs_n_s,
    input  logic [DATA_W-1:0] load_byte,
    output logic              miso,
    output logic              miso_oe,
    output logic              xfer_done
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    spi_state_t        state, state_nxt;
    logic              sck_d, cs_d;
    logic              cs_fall, cs_rise, sck_rise, sck_fall;
    logic [DATA_W-1:0] tx_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign cs_fall  = ~cs_n_s & cs_d;
    assign cs_rise  = cs_n_s & ~cs_d;
    assign sck_rise = sck_s & ~sck_d & ~cs_n_s;
    assign sck_fall = ~sck_s & sck_d & ~cs_n_s;

    // next-state logic
    always_comb begin
        state_nxt = state;
        xfer_done = 1'b0;
        unique case (state)
            SPI_IDLE: begin
                if (cs_fall) state_nxt = SPI_SHIFT;
            end
            SPI_SHIFT: begin
                if (cs_rise) begin
                    state_nxt = SPI_IDLE;
                end else if (sck_rise && cnt_q == LAST_BIT) begin
                    state_nxt = SPI_DONE;
                    xfer_done = 1'b1;
                end
            end
            SPI_DONE: begin
                if (cs_rise) state_nxt = SPI_IDLE;
            end
            default: state_nxt = SPI_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SPI_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // shift register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (state == SPI_IDLE && cs_fall) begin
                tx_q  <= load_byte;
                cnt_q <= '0;
            end else if (state == SPI_SHIFT && !cs_rise) begin
                if (sck_rise) begin
                    cnt_q <= cnt_q + 1'b1;
                end else if (sck_fall) begin
                    tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        miso    = 1'b0;
        miso_oe = 1'b0;
        unique case (state)
            SPI_IDLE:  begin miso = 1'b0;         miso_oe = 1'b0; end
            SPI_SHIFT: begin miso = tx_q[DATA_W-1]; miso_oe = 1'b1; end
            SPI_DONE:  begin miso = 1'b0;         miso_oe = 1'b1; end
            default:   begin miso = 1'b0;         miso_oe = 1'b0; end
        endcase
    end

    a_r5_load_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SPI_IDLE && cs_fall) |=> (tx_q == $past(load_byte)));

    a_r6_release_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe);

    a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> (state == SPI_DONE));

    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SPI_DONE && !cs_rise) |=> (state == SPI_DONE && !miso));

endmodule

// File: rtl/par_spi_echo.sv
module par_spi_echo #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_trig,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              data_ready
);

    // bit order of the synchroniser bank
    localparam int IDX_TRIG = 0;
    localparam int IDX_SCK  = 1;
    localparam int IDX_CS   = 2;
    localparam int N_SYNC   = 3;
    localparam logic [N_SYNC-1:0] SYNC_RST = N_SYNC'(1) << IDX_CS;

    logic [N_SYNC-1:0] raw_in, synced;
    logic [DATA_W-1:0] hold;
    logic              xfer_done;
    logic              cap_evt;

    always_comb begin
        raw_in           = '0;
        raw_in[IDX_TRIG] = host_trig;
        raw_in[IDX_SCK]  = spi_sck;
        raw_in[IDX_CS]   = spi_cs_n;
    end

    pse_sync #(
        .WIDTH   (N_SYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    pse_capture #(
        .DATA_W (DATA_W)
    ) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_s    (synced[IDX_TRIG]),
        .par_data  (host_data),
        .xfer_done (xfer_done),
        .hold      (hold),
        .ready     (data_ready),
        .cap_evt   (cap_evt)
    );

    pse_spi_tx #(
        .DATA_W (DATA_W)
    ) u_spi (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (synced[IDX_SCK]),
        .cs_n_s    (synced[IDX_CS]),
        .load_byte (hold),
        .miso      (spi_miso),
        .miso_oe   (spi_miso_oe),
        .xfer_done (xfer_done)
    );

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_miso_oe |-> !spi_miso);

    a_r8_capture_flags: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> data_ready);

endmodule

// File: tb/par_spi_echo_tb.sv
module par_spi_echo_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_data = 8'h00;
    logic       host_trig = 1'b0;
    logic       spi_sck = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_miso, spi_miso_oe, data_ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    par_spi_echo u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data   (host_data),
        .host_trig   (host_trig),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .data_ready  (data_ready)
    );

    // behavioural reference: inputs seen two cycles late, then edge events
    logic [2:0] h_trig, h_sck, h_cs;
    logic [7:0] m_hold, m_tx;
    int         m_phase, m_cnt;
    bit         m_ready;

    always @(posedge clk) begin
        if (!rst_n) begin
            h_trig = 3'b000; h_sck = 3'b000; h_cs = 3'b111;
            m_hold = 8'h00; m_tx = 8'h00; m_phase = 0; m_cnt = 0; m_ready = 0;
        end else begin
            bit rise, csf, csr, skr, skf, fin;
            rise = h_trig[1] && !h_trig[2];
            csf  = !h_cs[1] && h_cs[2];
            csr  = h_cs[1] && !h_cs[2];
            skr  = h_sck[1] && !h_sck[2] && !h_cs[1];
            skf  = !h_sck[1] && h_sck[2] && !h_cs[1];
            fin  = 0;
            if (m_phase == 0) begin
                if (csf) begin m_phase = 1; m_tx = m_hold; m_cnt = 0; end
            end else if (m_phase == 1) begin
                if (csr) m_phase = 0;
                else if (skr) begin
                    if (m_cnt == 7) begin m_phase = 2; fin = 1; end
                    m_cnt++;
                end else if (skf) m_tx = m_tx << 1;
            end else begin
                if (csr) m_phase = 0;
            end
            if (rise) m_ready = 1;
            else if (fin) m_ready = 0;
            if (rise) m_hold = host_data;
            h_trig = {h_trig[1:0], host_trig};
            h_sck  = {h_sck[1:0], spi_sck};
            h_cs   = {h_cs[1:0], spi_cs_n};
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            check("R5 miso vs model", {7'd0, spi_miso}, {7'd0, (m_phase == 1) ? m_tx[7] : 1'b0});
            check("R6 miso_oe vs model", {7'd0, spi_miso_oe}, {7'd0, m_phase != 0});
            check("R7 data_ready vs model", {7'd0, data_ready}, {7'd0, m_ready});
        end
    end

    localparam int HALF = 6;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic capture(input logic [7:0] v);
        host_trig = 1'b0; wait_clk(3);
        host_data = v;    wait_clk(2);
        host_trig = 1'b1; wait_clk(4);
    endtask

    task automatic spi_read(input int nbits, input int extra_sck, output logic [7:0] got);
        got = 8'h00;
        spi_cs_n = 1'b0; wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            got = {got[6:0], spi_miso};
            spi_sck = 1'b1; wait_clk(HALF);
            spi_sck = 1'b0; wait_clk(HALF);
        end
        for (int i = 0; i < extra_sck; i++) begin
            check("R9 miso quiet after byte", {7'd0, spi_miso}, 8'd0);
            check("R9 oe held after byte", {7'd0, spi_miso_oe}, 8'd1);
            spi_sck = 1'b1; wait_clk(HALF);
            spi_sck = 1'b0; wait_clk(HALF);
        end
        spi_cs_n = 1'b1; wait_clk(HALF);
    endtask

    initial begin
        #1500000;
        if (!done_flag) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            done_flag = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] got;
        wait_clk(4);
        check("R1 ready at reset", {7'd0, data_ready}, 8'd0);
        check("R1 miso at reset", {7'd0, spi_miso}, 8'd0);
        check("R1 oe at reset", {7'd0, spi_miso_oe}, 8'd0);
        rst_n = 1'b1;
        wait_clk(3);

        // R2: exact latency of capture
        host_data = 8'hA5; wait_clk(2);
        host_trig = 1'b1;
        wait_clk(2);
        check("R2 ready still low after 2 edges", {7'd0, data_ready}, 8'd0);
        wait_clk(1);
        check("R2 ready high after 3 edges", {7'd0, data_ready}, 8'd1);
        wait_clk(2);

        // R5/R7: full read
        spi_read(8, 0, got);
        check("R5 echoed byte", got, 8'hA5);
        check("R7 ready cleared by full read", {7'd0, data_ready}, 8'd0);

        // R3: level high with changing data, then falling edge
        host_data = 8'h11; wait_clk(4);
        host_data = 8'h22; wait_clk(4);
        host_trig = 1'b0;  wait_clk(5);
        check("R3 no capture on level/fall", {7'd0, data_ready}, 8'd0);
        // R4: data changes while low
        host_data = 8'h33; wait_clk(5);
        check("R4 no capture while low", {7'd0, data_ready}, 8'd0);
        spi_read(8, 0, got);
        check("R3 held byte unchanged", got, 8'hA5);

        // R6: SCK toggling while deselected
        capture(8'h3C);
        for (int i = 0; i < 4; i++) begin
            spi_sck = 1'b1; wait_clk(HALF);
            check("R6 miso while deselected", {7'd0, spi_miso}, 8'd0);
            check("R6 oe while deselected", {7'd0, spi_miso_oe}, 8'd0);
            spi_sck = 1'b0; wait_clk(HALF);
        end
        check("R6 ready untouched", {7'd0, data_ready}, 8'd1);

        // R7: partial transfer keeps flag
        spi_read(4, 0, got);
        check("R7 partial bits MSB first", got, 8'h03);
        check("R7 partial keeps ready", {7'd0, data_ready}, 8'd1);

        // R8: capture during a transfer
        got = 8'h00;
        spi_cs_n = 1'b0; wait_clk(HALF);
        for (int i = 0; i < 8; i++) begin
            got = {got[6:0], spi_miso};
            if (i == 2) begin
                host_trig = 1'b0; wait_clk(3);
                host_data = 8'hF0; wait_clk(2);
                host_trig = 1'b1; wait_clk(4);
            end
            spi_sck = 1'b1; wait_clk(HALF);
            spi_sck = 1'b0; wait_clk(HALF);
        end
        spi_cs_n = 1'b1; wait_clk(HALF);
        check("R8 shifted byte unaffected", got, 8'h3C);
        spi_read(8, 0, got);
        check("R8 next read returns new byte", got, 8'hF0);

        // R9: extra SCK after eight bits
        capture(8'h96);
        spi_read(8, 3, got);
        check("R9 byte before extra clocks", got, 8'h96);
        check("R9 ready cleared", {7'd0, data_ready}, 8'd0);

        // further patterns
        capture(8'h01);
        spi_read(8, 0, got);
        check("R5 pattern 01", got, 8'h01);
        capture(8'hFF);
        spi_read(8, 0, got);
        check("R5 pattern FF", got, 8'hFF);

        wait_clk(4);
        done_flag = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule